// File: doc/BRIEF.md
# Per-Token Value Quantizer

This block compresses one attention value vector per transaction. A token of D signed channels is accepted whole. The block scans the channels for the largest magnitude, and that magnitude becomes the token's scale. Each channel is then divided by the quantization step, and the result is rounded to a signed code. The code is 4-bit when the tier input is 0 and 8-bit when it is 1. Tokens are never grouped. The same block also expands records on the read side. A value record is dequantized into fixed-point values with F fractional bits. A key record carries an already expanded vector from the neighbouring key path, and the block passes that vector through; the record's tag chooses between the two.

One serial restoring divider is shared by every channel and by both directions, so the block handles one transaction at a time. The controller is a single state machine:

- IDLE: waits for work. It accepts a compress request before a read request.
- AMAX: scans one channel per cycle to find the largest magnitude.
- QSTART / QWAIT: launch the per-channel quantizing divide, then wait for it and store the rounded, saturated code.
- QDONE: presents the compressed token until it is taken.
- DSTART / DWAIT: the same pair of steps, used for dequantizing a value record.
- DDONE: presents the read result until it is taken.

The transitions are:

- IDLE→AMAX on `in_valid`.
- IDLE→DSTART on `dq_valid` with tag 1.
- IDLE→DDONE on `dq_valid` with tag 0.
- AMAX→QSTART after the last channel.
- QSTART→QWAIT always.
- QWAIT→QSTART when the divider finishes and channels remain.
- QWAIT→QDONE when the divider finishes on the last channel.
- QDONE→IDLE on `out_ready`.
- DSTART→DWAIT always.
- DWAIT→DSTART or DDONE, in the same way as QWAIT.
- DDONE→IDLE on `dr_ready`.

Top module: `vq_token_quant`

## Requirements
- R1: `out_scale` equals the largest magnitude among the D channels of the accepted token, as an unsigned DW-bit number. A channel of value -2^(DW-1) gives 2^(DW-1).
- R2: With tier 0, code i is round(x_i·7/scale) with ties to even, limited to [-7,7]. It is placed as 8-bit two's complement in `out_codes[8i+7:8i]`.
- R3: With tier 1, the code is computed as in R2 with 127 in place of 7, limited to [-127,127].
- R4: A token whose channels are all zero gives scale 0 and all codes 0. A value record with scale 0 dequantizes to all zeros.
- R5: The tier is sampled only in the accepting cycle. Later changes to `in_tier` or `dq_tier` have no effect on that transaction, and `out_tier` reports the sampled tier.
- R6: A value record (`dq_tag`=1) gives y_i = sign(c_i)·round(|c_i|·scale·2^F/Q) with ties to even. Q is 7 for `dq_tier` 0 and 127 for `dq_tier` 1. Each y_i is OW-bit two's complement in `dr_data[OW·i+OW-1:OW·i]`, with OW=DW+F+5.
- R7: A key record (`dq_tag`=0) puts `dq_key` unchanged on `dr_data`. `dr_valid` rises in the cycle after acceptance.
- R8: With NW=DW+F+8, `out_valid` first rises D·(NW+3) cycles after the compress acceptance edge. `dr_valid` for a value record first rises D·(NW+2) cycles after its acceptance edge.
- R9: Only one transaction runs at a time. `in_ready` is high only in IDLE, and `dq_ready` is high only in IDLE while `in_valid` is low, so compression takes priority.
- R10: While a result is valid and not taken, the result and its valid signal hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | token offered for compression |
| in_ready | output | 1 | token accepted this cycle when both are high |
| in_vec | input | D·DW | D signed channels, channel i at [DW·i+DW-1:DW·i] |
| in_tier | input | 1 | 0 = 4-bit codes, 1 = 8-bit codes |
| out_valid | output | 1 | compressed token available |
| out_ready | input | 1 | compressed token taken |
| out_scale | output | DW | token scale (largest magnitude) |
| out_tier | output | 1 | tier used for this token |
| out_codes | output | D·8 | signed codes, one byte per channel |
| dq_valid | input | 1 | record offered for expansion |
| dq_ready | output | 1 | record accepted this cycle when both are high |
| dq_tag | input | 1 | 1 = value record, 0 = key record |
| dq_tier | input | 1 | tier of a value record |
| dq_scale | input | DW | scale of a value record |
| dq_codes | input | D·8 | codes of a value record |
| dq_key | input | D·OW | expanded key vector from the key path |
| dr_valid | output | 1 | read result available |
| dr_ready | input | 1 | read result taken |
| dr_data | output | D·OW | expanded vector |

## Verification
Every result arrives at a fixed distance from its acceptance edge:

- compressed token: D·(NW+3) cycles;
- dequantized value record: D·(NW+2) cycles;
- key record: one cycle.

The bench model counts clock edges from each predicted handshake. On every falling edge it compares both ready outputs and both valid outputs against that count. Whenever a result is valid, it also compares the data against values the model computed at acceptance from the arithmetic rules. A valid that comes one cycle early or late is therefore reported at once, and so are held data that drift under backpressure.

// File: rtl/vq_pkg.sv
package vq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_AMAX,
        S_QSTART,
        S_QWAIT,
        S_QDONE,
        S_DSTART,
        S_DWAIT,
        S_DDONE
    } vq_state_e;

    localparam int CODE_W = 8;
endpackage

// File: rtl/vq_serdiv.sv
// Restoring divider, one quotient bit per cycle, fin pulses when done.
module vq_serdiv #(
    parameter int NW   = 24,
    parameter int DENW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   num,
    input  logic [DENW-1:0] den,
    output logic            fin,
    output logic [NW-1:0]   quo,
    output logic [DENW-1:0] rem
);
    localparam int CNTW = $clog2(NW + 1);

    logic [NW-1:0]   q_r;
    logic [DENW-1:0] r_r;
    logic [DENW-1:0] d_r;
    logic [CNTW-1:0] cnt_r;
    logic            busy_r;
    logic [DENW:0]   trial;
    logic [DENW:0]   diff;
    logic            ge;

    always_comb begin
        trial = {r_r, q_r[NW-1]};
        ge    = trial >= {1'b0, d_r};
        diff  = trial - {1'b0, d_r};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            r_r    <= '0;
            d_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                q_r    <= num;
                r_r    <= '0;
                d_r    <= den;
                cnt_r  <= CNTW'(NW);
                busy_r <= 1'b1;
            end else if (busy_r) begin
                q_r   <= {q_r[NW-2:0], ge};
                r_r   <= ge ? diff[DENW-1:0] : trial[DENW-1:0];
                cnt_r <= cnt_r - CNTW'(1);
                if (cnt_r == CNTW'(1)) begin
                    busy_r <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;
    assign rem = r_r;
endmodule

// File: rtl/vq_rne.sv
// Round a quotient to nearest, ties to even, then apply the sign.
module vq_rne #(
    parameter int QW   = 24,
    parameter int DENW = 12
) (
    input  logic [QW-1:0]   quo,
    input  logic [DENW-1:0] rem,
    input  logic [DENW-1:0] den,
    input  logic            neg,
    output logic signed [QW:0] res
);
    logic         up;
    logic [QW:0]  mag;

    always_comb begin
        up  = ({rem, 1'b0} > {1'b0, den}) ||
              (({rem, 1'b0} == {1'b0, den}) && quo[0]);
        mag = {1'b0, quo} + (QW+1)'(up);
        res = neg ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/vq_token_quant.sv
module vq_token_quant #(
    parameter int D  = 8,
    parameter int DW = 12,
    parameter int F  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [D*DW-1:0]               in_vec,
    input  logic                          in_tier,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [DW-1:0]                 out_scale,
    output logic                          out_tier,
    output logic [D*vq_pkg::CODE_W-1:0]   out_codes,
    input  logic                          dq_valid,
    output logic                          dq_ready,
    input  logic                          dq_tag,
    input  logic                          dq_tier,
    input  logic [DW-1:0]                 dq_scale,
    input  logic [D*vq_pkg::CODE_W-1:0]   dq_codes,
    input  logic [D*(DW+F+5)-1:0]         dq_key,
    output logic                          dr_valid,
    input  logic                          dr_ready,
    output logic [D*(DW+F+5)-1:0]         dr_data
);
    import vq_pkg::*;

    localparam int NW = DW + F + 8;
    localparam int OW = DW + F + 5;
    localparam int CW = CODE_W;
    localparam int IW = (D > 1) ? $clog2(D) : 1;

    vq_state_e state, nxt;

    logic [IW-1:0]              idx;
    logic                       last;
    logic [D-1:0][DW-1:0]       vec_r;
    logic [D-1:0][CW-1:0]       codes_r;
    logic [D-1:0][CW-1:0]       dcodes_r;
    logic [D-1:0][OW-1:0]       res_r;
    logic [DW-1:0]              amax_r;
    logic [DW-1:0]              dscale_r;
    logic                       tier_r;

    logic signed [DW-1:0]       cur_x;
    logic [DW-1:0]              cur_mag;
    logic signed [CW-1:0]       cur_c;
    logic [CW-1:0]              c_mag;
    logic [DW-1:0]              qlim;
    logic                       qmode;
    logic                       div_start;
    logic [NW-1:0]              div_num;
    logic [DW-1:0]              div_den;
    logic                       div_fin;
    logic [NW-1:0]              div_quo;
    logic [DW-1:0]              div_rem;
    logic                       rnd_neg;
    logic signed [NW:0]         rnd;
    logic signed [NW:0]         lim_s;
    logic [CW-1:0]              qcode;

    // Shared arithmetic: one divider, one rounder.
    vq_serdiv #(.NW(NW), .DENW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .fin   (div_fin),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    vq_rne #(.QW(NW), .DENW(DW)) u_rne (
        .quo (div_quo),
        .rem (div_rem),
        .den (div_den),
        .neg (rnd_neg),
        .res (rnd)
    );

    always_comb begin
        last    = (idx == IW'(D - 1));
        cur_x   = vec_r[idx];
        cur_mag = cur_x[DW-1] ? DW'(-cur_x) : DW'(cur_x);
        cur_c   = dcodes_r[idx];
        c_mag   = cur_c[CW-1] ? CW'(-cur_c) : CW'(cur_c);
        qlim    = tier_r ? DW'(127) : DW'(7);
        qmode   = (state == S_QSTART) || (state == S_QWAIT);
        div_num = qmode ? NW'(cur_mag) * NW'(qlim)
                        : (NW'(c_mag) * NW'(dscale_r)) << F;
        div_den = qmode ? amax_r : qlim;
        rnd_neg = qmode ? cur_x[DW-1] : cur_c[CW-1];
        lim_s   = $signed((NW+1)'(qlim));
        if (amax_r == '0)
            qcode = '0;
        else if (rnd > lim_s)
            qcode = qlim[CW-1:0];
        else if (rnd < -lim_s)
            qcode = -qlim[CW-1:0];
        else
            qcode = rnd[CW-1:0];
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (in_valid)      nxt = S_AMAX;
                else if (dq_valid) nxt = dq_tag ? S_DSTART : S_DDONE;
            end
            S_AMAX:   if (last) nxt = S_QSTART;
            S_QSTART: nxt = S_QWAIT;
            S_QWAIT:  if (div_fin) nxt = last ? S_QDONE : S_QSTART;
            S_QDONE:  if (out_ready) nxt = S_IDLE;
            S_DSTART: nxt = S_DWAIT;
            S_DWAIT:  if (div_fin) nxt = last ? S_DDONE : S_DSTART;
            S_DDONE:  if (dr_ready) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            vec_r    <= '0;
            codes_r  <= '0;
            dcodes_r <= '0;
            res_r    <= '0;
            amax_r   <= '0;
            dscale_r <= '0;
            tier_r   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    idx <= '0;
                    if (in_valid) begin
                        vec_r  <= in_vec;
                        tier_r <= in_tier;
                        amax_r <= '0;
                    end else if (dq_valid) begin
                        dcodes_r <= dq_codes;
                        tier_r   <= dq_tier;
                        dscale_r <= dq_scale;
                        if (!dq_tag) res_r <= dq_key;
                    end
                end
                S_AMAX: begin
                    if (cur_mag > amax_r) amax_r <= cur_mag;
                    idx <= last ? '0 : idx + IW'(1);
                end
                S_QWAIT: if (div_fin) begin
                    codes_r[idx] <= qcode;
                    idx <= last ? '0 : idx + IW'(1);
                end
                S_DWAIT: if (div_fin) begin
                    res_r[idx] <= rnd[OW-1:0];
                    idx <= last ? '0 : idx + IW'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        div_start = (state == S_QSTART) || (state == S_DSTART);
        in_ready  = (state == S_IDLE);
        dq_ready  = (state == S_IDLE) && !in_valid;
        out_valid = (state == S_QDONE);
        dr_valid  = (state == S_DDONE);
        out_scale = amax_r;
        out_tier  = tier_r;
        out_codes = codes_r;
        dr_data   = res_r;
    end
endmodule

// File: rtl/vq_token_quant_chk.sv
module vq_token_quant_chk #(
    parameter int D  = 8,
    parameter int DW = 12,
    parameter int F  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [DW-1:0]        out_scale,
    input logic                 out_tier,
    input logic [D*8-1:0]       out_codes,
    input logic                 dq_valid,
    input logic                 dq_ready,
    input logic                 dq_tag,
    input logic [D*(DW+F+5)-1:0] dq_key,
    input logic                 dr_valid,
    input logic                 dr_ready,
    input logic [D*(DW+F+5)-1:0] dr_data
);
    p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_codes)
                                    && $stable(out_scale) && $stable(out_tier));

    p_hold_dr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_data));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid && !dr_valid);

    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> !dq_ready);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, dr_valid}));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready && !out_valid);

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_scale == '0) |-> (out_codes == '0));

    p_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid && dq_ready && !dq_tag |=> dr_valid && (dr_data == $past(dq_key)));

    for (genvar i = 0; i < D; i++) begin : g_rng
        p_range_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'($signed(out_codes[i*8 +: 8])) <= (out_tier ? 127 : 7))
                       && (int'($signed(out_codes[i*8 +: 8])) >= (out_tier ? -127 : -7)));
    end
endmodule

bind vq_token_quant vq_token_quant_chk #(.D(D), .DW(DW), .F(F)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_scale (out_scale),
    .out_tier  (out_tier),
    .out_codes (out_codes),
    .dq_valid  (dq_valid),
    .dq_ready  (dq_ready),
    .dq_tag    (dq_tag),
    .dq_key    (dq_key),
    .dr_valid  (dr_valid),
    .dr_ready  (dr_ready),
    .dr_data   (dr_data)
);

// File: tb/vq_token_quant_bench.sv
`timescale 1ns/1ps
module vq_token_quant_bench;
    localparam int D  = 8;
    localparam int DW = 12;
    localparam int F  = 4;
    localparam int NW = DW + F + 8;
    localparam int OW = DW + F + 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0, in_tier = 1'b0;
    logic [D*DW-1:0]    in_vec = '0;
    logic               out_ready = 1'b1;
    logic               dq_valid = 1'b0, dq_tag = 1'b0, dq_tier = 1'b0;
    logic [DW-1:0]      dq_scale = '0;
    logic [D*8-1:0]     dq_codes = '0;
    logic [D*OW-1:0]    dq_key = '0;
    logic               dr_ready = 1'b1;
    logic               in_ready, out_valid, out_tier, dq_ready, dr_valid;
    logic [DW-1:0]      out_scale;
    logic [D*8-1:0]     out_codes;
    logic [D*OW-1:0]    dr_data;

    vq_token_quant #(.D(D), .DW(DW), .F(F)) u_vq_token_quant (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec), .in_tier(in_tier),
        .out_valid(out_valid), .out_ready(out_ready), .out_scale(out_scale),
        .out_tier(out_tier), .out_codes(out_codes),
        .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_tag(dq_tag), .dq_tier(dq_tier),
        .dq_scale(dq_scale), .dq_codes(dq_codes), .dq_key(dq_key),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_data(dr_data)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;
    string tag_next = "R1";
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint rne(longint n, longint d);
        longint q = n / d;
        longint r = n % d;
        if (2 * r > d || (2 * r == d && (q % 2) == 1)) q++;
        return q;
    endfunction

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // ---------------- reference model ----------------
    bit     busy_m = 0, acc_p = 0, clr_p = 0;
    int     kind_m = 0, acc_kind = 0, cnt_m = 0;
    string  tag_m = "", acc_tag = "";
    longint e_scale, a_scale;
    bit     e_tier, a_tier;
    longint e_code [D], a_code [D];
    longint e_dq [D], a_dq [D];
    logic [D*OW-1:0] e_key, a_key;

    function automatic int lat(int k);
        if (k == 0) return D * (NW + 3);
        if (k == 1) return D * (NW + 2);
        return 0;
    endfunction

    task automatic predict_comp();
        longint m = 0, q;
        for (int i = 0; i < D; i++) begin
            longint x = longint'($signed(in_vec[i*DW +: DW]));
            if ((x < 0 ? -x : x) > m) m = (x < 0 ? -x : x);
        end
        q = in_tier ? 127 : 7;
        a_scale = m; a_tier = in_tier;
        for (int i = 0; i < D; i++) begin
            longint x = longint'($signed(in_vec[i*DW +: DW]));
            longint c = (m == 0) ? 0 : rne((x < 0 ? -x : x) * q, m);
            if (c > q) c = q;
            a_code[i] = (x < 0) ? -c : c;
        end
    endtask

    task automatic predict_dq();
        longint q = dq_tier ? 127 : 7;
        a_key = dq_key;
        for (int i = 0; i < D; i++) begin
            longint c = longint'($signed(dq_codes[i*8 +: 8]));
            longint y = rne((c < 0 ? -c : c) * longint'(dq_scale) * (64'sd1 <<< F), q);
            a_dq[i] = (c < 0) ? -y : y;
        end
    endtask

    always @(negedge clk) begin
        bit ev_out, ev_dr;
        cycles++;
        if (!finished && cycles > 100000) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
        if (rst_n) begin
            if (acc_p) begin
                busy_m = 1; kind_m = acc_kind; cnt_m = 1; tag_m = acc_tag; acc_p = 0;
                e_scale = a_scale; e_tier = a_tier; e_key = a_key;
                e_code = a_code; e_dq = a_dq;
            end else if (clr_p) begin
                busy_m = 0; clr_p = 0;
            end else if (busy_m) cnt_m++;

            ev_out = busy_m && kind_m == 0 && cnt_m >= lat(0) + 1;
            ev_dr  = busy_m && kind_m != 0 && cnt_m >= lat(kind_m) + 1;

            chk(in_ready == !busy_m, "R9", "in_ready", in_ready, !busy_m);
            chk(dq_ready == (!busy_m && !in_valid), "R9", "dq_ready",
                dq_ready, !busy_m && !in_valid);
            chk(out_valid == ev_out, "R8", "out_valid timing", out_valid, ev_out);
            chk(dr_valid == ev_dr, "R8", "dr_valid timing", dr_valid, ev_dr);

            if (ev_out && out_valid) begin
                chk(out_scale == e_scale, tag_m, "scale", out_scale, e_scale);
                chk(out_tier == e_tier, tag_m, "tier", out_tier, e_tier);
                for (int i = 0; i < D; i++)
                    chk(longint'($signed(out_codes[i*8 +: 8])) == e_code[i], tag_m, "code",
                        longint'($signed(out_codes[i*8 +: 8])), e_code[i]);
            end
            if (ev_dr && dr_valid) begin
                if (kind_m == 2)
                    chk(dr_data == e_key, tag_m, "key passthrough",
                        longint'(dr_data[63:0]), longint'(e_key[63:0]));
                else
                    for (int i = 0; i < D; i++)
                        chk(longint'($signed(dr_data[i*OW +: OW])) == e_dq[i], tag_m, "dequant",
                            longint'($signed(dr_data[i*OW +: OW])), e_dq[i]);
            end

            if (!busy_m && in_valid) begin
                acc_p = 1; acc_kind = 0; acc_tag = tag_next; predict_comp();
            end else if (!busy_m && dq_valid) begin
                acc_p = 1; acc_kind = dq_tag ? 1 : 2; acc_tag = tag_next; predict_dq();
            end
            if ((ev_out && out_ready) || (ev_dr && dr_ready)) clr_p = 1;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [D*DW-1:0] pat(int p);
        logic [D*DW-1:0] v;
        int ties [8] = '{14, 1, 3, 5, -3, -5, 0, -14};
        for (int i = 0; i < D; i++) begin
            int x;
            case (p)
                0: x = i * 100 - 300;
                1: x = ties[i % 8];
                2: x = 0;
                3: x = (i == D / 2) ? -2048 : i * 37 - 100;
                default: x = int'(lcg() & 32'hFFF) - 2048;
            endcase
            v[i*DW +: DW] = DW'(x);
        end
        return v;
    endfunction

    task automatic wait_result();
        do @(negedge clk); while (!(out_valid || dr_valid));
        @(posedge clk);
        #1;
    endtask

    task automatic comp(input logic [D*DW-1:0] v, input bit t, input string tg, input bit flip);
        tag_next = tg;
        in_vec = v; in_tier = t; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (flip) in_tier = ~t;
        wait_result();
    endtask

    task automatic dq(input bit tg_bit, input bit t, input int sc, input string tg);
        tag_next = tg;
        for (int i = 0; i < D; i++) begin
            int q = t ? 127 : 7;
            dq_codes[i*8 +: 8] = 8'(int'(lcg() % (2 * q + 1)) - q);
        end
        for (int i = 0; i < D * OW; i += 16) dq_key[i +: 16] = 16'(lcg());
        dq_scale = DW'(sc); dq_tier = t; dq_tag = tg_bit; dq_valid = 1'b1;
        do @(negedge clk); while (!dq_ready);
        @(posedge clk); #1;
        dq_valid = 1'b0;
        dq_tier = ~t;
        wait_result();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && dr_valid == 1'b0, "R9",
            "reset state", {in_ready, out_valid, dr_valid}, 3'b100);
        @(posedge clk); #1;

        comp(pat(0), 1'b0, "R1", 1'b0);
        comp(pat(0), 1'b1, "R3", 1'b0);
        comp(pat(1), 1'b0, "R2", 1'b0);
        comp(pat(2), 1'b0, "R4", 1'b0);
        comp(pat(2), 1'b1, "R4", 1'b0);
        comp(pat(3), 1'b0, "R1", 1'b0);
        comp(pat(3), 1'b1, "R3", 1'b0);
        comp(pat(4), 1'b0, "R5", 1'b1);
        comp(pat(4), 1'b1, "R5", 1'b1);
        for (int k = 0; k < 4; k++) comp(pat(4), k[0], "R2", 1'b0);

        dq(1'b1, 1'b0, 1000, "R6");
        dq(1'b1, 1'b1, 2048, "R6");
        dq(1'b1, 1'b0, 0, "R4");
        dq(1'b1, 1'b1, 3, "R5");
        dq(1'b0, 1'b0, 0, "R7");
        dq(1'b0, 1'b1, 0, "R7");

        // Backpressure on both result ports.
        out_ready = 1'b0;
        tag_next = "R10";
        in_vec = pat(4); in_tier = 1'b1; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1 in_valid = 1'b0;
        do @(negedge clk); while (!out_valid);
        repeat (6) @(negedge clk);
        @(posedge clk); #1 out_ready = 1'b1;
        @(posedge clk); #1;
        dr_ready = 1'b0;
        tag_next = "R10";
        dq_tag = 1'b1; dq_tier = 1'b0; dq_scale = DW'(777); dq_valid = 1'b1;
        do @(negedge clk); while (!dq_ready);
        @(posedge clk); #1 dq_valid = 1'b0;
        do @(negedge clk); while (!dr_valid);
        repeat (6) @(negedge clk);
        @(posedge clk); #1 dr_ready = 1'b1;
        @(posedge clk); #1;

        // Compression wins when both requests arrive together.
        tag_next = "R9";
        in_vec = pat(0); in_tier = 1'b0; in_valid = 1'b1;
        dq_tag = 1'b0; dq_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1 in_valid = 1'b0;
        do @(negedge clk); while (!dq_ready);
        @(posedge clk); #1 dq_valid = 1'b0;
        wait_result();
        repeat (3) @(posedge clk);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule